// File: doc/BRIEF.md
# Configurable Logic-Array Macrocell Slice

This block is the storage and output stage that follows the OR term of a sum-of-products logic array. It is built as a slice of `LANES` identical cells that share one static configuration word. Each lane takes a sum-term bit from the array and returns two values. The first is a feedback value that goes back into the array. The second is a pin-drive value with an output enable.

The configuration selects one of three output modes: combinatorial, transparent latch, or flip-flop. In flip-flop mode it also selects D or T storage, and it chooses which of two clock strobes advances the flip-flop. The polarity of the pin value is programmable.

The whole design runs on one system clock. The two selectable clocks appear as clock-enable strobes (`tick_a`, `tick_b`). The latch is transparent within a cycle, and the value it holds is captured at the clock edge.

A build-time option adds an input-capture stage for each lane. This stage takes the external pin value into a register or a transparent latch, so that an asynchronous signal can enter the array synchronised. When a lane is configured as buried logic, its pin driver is switched off, which leaves the pin free to serve as an input.

Top module: `mc_macrocell`

## Requirements
- R1: With `cfg_mode` = 0 (combinatorial), `fb_out` equals `sum_in` in the same cycle.
- R2: With `cfg_mode` = 1 (latch), `fb_out` equals `sum_in` while `latch_en` is 1. While `latch_en` is 0, `fb_out` keeps the `sum_in` value from the last clock edge at which `latch_en` was 1.
- R3: With `cfg_mode` = 2 or 3 (flip-flop) and `cfg_t_type` = 0 (D storage), each clock edge at which the selected strobe is 1 loads `sum_in` into the lane, and `fb_out` shows it from the next cycle. At any other edge the value is held.
- R4: With flip-flop mode and `cfg_t_type` = 1 (T storage), a selected-strobe edge inverts each lane whose `sum_in` bit is 1. Lanes whose bit is 0 keep their value.
- R5: With `cfg_clk_sel` = 0, `tick_a` is the flip-flop strobe. With `cfg_clk_sel` = 1, `tick_b` is the strobe. The strobe that is not selected has no effect on `fb_out` or `in_fb`.
- R6: `pin_out` equals `fb_out` XOR `cfg_invert` in every lane, and `fb_out` is never inverted.
- R7: `pin_oe` is 0 when `cfg_buried` = 1 and 1 when `cfg_buried` = 0.
- R8: With `cfg_in_latch` = 0, `in_fb` takes `pin_in` at each selected-strobe edge and holds at any other edge.
- R9: With `cfg_in_latch` = 1, `in_fb` equals `pin_in` while `latch_en` is 1. Otherwise it holds the `pin_in` value from the last edge at which `latch_en` was 1.
- R10: A synchronous reset (`rst` = 1 at an edge) clears the flip-flop, the latch and the input-capture state to 0, before any polarity inversion is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_a | input | 1 | Clock strobe A |
| tick_b | input | 1 | Clock strobe B |
| latch_en | input | 1 | Latch transparency enable |
| sum_in | input | LANES | Sum terms from the array |
| pin_in | input | LANES | External pin values |
| cfg_mode | input | 2 | 0 comb, 1 latch, 2/3 flip-flop |
| cfg_t_type | input | 1 | 1 selects T storage |
| cfg_invert | input | 1 | Invert the pin value |
| cfg_clk_sel | input | 1 | 0 strobe A, 1 strobe B |
| cfg_buried | input | 1 | Disable the pin driver |
| cfg_in_latch | input | 1 | Input capture as a latch instead of a register |
| pin_out | output | LANES | Pin drive values |
| pin_oe | output | 1 | Pin output enable |
| fb_out | output | LANES | Feedback to the array |
| in_fb | output | LANES | Captured pin input to the array |

## Verification
The bench uses the default `LANES` = 4 and `HAS_INCAP` = 1. With these values the input-capture stage is present, and four independent lanes can show T-mode toggling on some bits while others hold within a single cycle. The bench visits all 96 combinations of mode, storage type, polarity, strobe select, buried and input-capture style. Each combination starts from reset and runs with random strobes, so the unselected strobe regularly pulses when it must be ignored.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        MODE_COMB  = 2'd0,
        MODE_LATCH = 2'd1,
        MODE_REG   = 2'd2
    } out_mode_e;

    typedef struct packed {
        out_mode_e mode;
        logic      t_type;
        logic      invert;
        logic      clk_sel;
        logic      buried;
        logic      in_latch;
    } mc_cfg_t;

    function automatic out_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd0:    return MODE_COMB;
            2'd1:    return MODE_LATCH;
            default: return MODE_REG;
        endcase
    endfunction

    function automatic logic next_bit(input logic t_type, input logic q, input logic s);
        return t_type ? (q ^ s) : s;
    endfunction

endpackage

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             latch_en,
    input  out_mode_e        mode,
    input  logic             t_type,
    input  logic [LANES-1:0] sum,
    output logic [LANES-1:0] fb
);
    logic [LANES-1:0] ff_q;
    logic [LANES-1:0] hold_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                ff_q[i]   <= 1'b0;
                hold_q[i] <= 1'b0;
            end else begin
                if (tick)
                    ff_q[i] <= next_bit(t_type, ff_q[i], sum[i]);
                if (latch_en)
                    hold_q[i] <= sum[i];
            end
        end

        always_comb begin
            case (mode)
                MODE_COMB:  fb[i] = sum[i];
                MODE_LATCH: fb[i] = latch_en ? sum[i] : hold_q[i];
                default:    fb[i] = ff_q[i];
            endcase
        end
    end
endmodule

// File: rtl/mc_incap.sv
module mc_incap #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             latch_en,
    input  logic             as_latch,
    input  logic [LANES-1:0] pin,
    output logic [LANES-1:0] cap
);
    logic [LANES-1:0] cap_q;
    logic             load;

    assign load = as_latch ? latch_en : tick;

    always_ff @(posedge clk) begin
        if (rst)
            cap_q <= '0;
        else if (load)
            cap_q <= pin;
    end

    assign cap = (as_latch && latch_en) ? pin : cap_q;
endmodule

// File: rtl/mc_outpath.sv
module mc_outpath #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] fb,
    input  logic             invert,
    input  logic             buried,
    output logic [LANES-1:0] pin_val,
    output logic             oe
);
    assign pin_val = fb ^ {LANES{invert}};
    assign oe      = ~buried;
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
    import mc_pkg::*;
#(
    parameter int LANES     = 4,
    parameter bit HAS_INCAP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_a,
    input  logic             tick_b,
    input  logic             latch_en,
    input  logic [LANES-1:0] sum_in,
    input  logic [LANES-1:0] pin_in,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_t_type,
    input  logic             cfg_invert,
    input  logic             cfg_clk_sel,
    input  logic             cfg_buried,
    input  logic             cfg_in_latch,
    output logic [LANES-1:0] pin_out,
    output logic             pin_oe,
    output logic [LANES-1:0] fb_out,
    output logic [LANES-1:0] in_fb
);
    mc_cfg_t cfg;
    logic    sel_tick;

    assign cfg.mode     = decode_mode(cfg_mode);
    assign cfg.t_type   = cfg_t_type;
    assign cfg.invert   = cfg_invert;
    assign cfg.clk_sel  = cfg_clk_sel;
    assign cfg.buried   = cfg_buried;
    assign cfg.in_latch = cfg_in_latch;

    assign sel_tick = cfg.clk_sel ? tick_b : tick_a;

    mc_store #(.LANES(LANES)) store_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (sel_tick),
        .latch_en (latch_en),
        .mode     (cfg.mode),
        .t_type   (cfg.t_type),
        .sum      (sum_in),
        .fb       (fb_out)
    );

    mc_outpath #(.LANES(LANES)) out_i (
        .fb      (fb_out),
        .invert  (cfg.invert),
        .buried  (cfg.buried),
        .pin_val (pin_out),
        .oe      (pin_oe)
    );

    if (HAS_INCAP) begin : g_incap
        mc_incap #(.LANES(LANES)) incap_i (
            .clk      (clk),
            .rst      (rst),
            .tick     (sel_tick),
            .latch_en (latch_en),
            .as_latch (cfg.in_latch),
            .pin      (pin_in),
            .cap      (in_fb)
        );
    end else begin : g_direct
        assign in_fb = pin_in;
    end
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_a,
    input logic             tick_b,
    input logic             latch_en,
    input logic [LANES-1:0] sum_in,
    input logic [1:0]       cfg_mode,
    input logic             cfg_t_type,
    input logic             cfg_invert,
    input logic             cfg_clk_sel,
    input logic             cfg_buried,
    input logic [LANES-1:0] pin_out,
    input logic             pin_oe,
    input logic [LANES-1:0] fb_out
);
    logic strobe;
    assign strobe = cfg_clk_sel ? tick_b : tick_a;

    // R1
    comb_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'd0) |-> (fb_out == sum_in));

    // R2
    latch_open_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'd1 && latch_en) |-> (fb_out == sum_in));

    // R3
    dff_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode[1] && !cfg_t_type && strobe) |=>
        (!$stable(cfg_mode) || !$stable(cfg_t_type) || fb_out == $past(sum_in)));

    // R4
    tff_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode[1] && cfg_t_type && strobe) |=>
        (!$stable(cfg_mode) || !$stable(cfg_t_type) || fb_out == ($past(fb_out) ^ $past(sum_in))));

    // R5
    ff_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode[1] && !strobe) |=>
        (!$stable(cfg_mode) || !$stable(cfg_clk_sel) || $stable(fb_out)));

    // R6
    polarity_chk: assert property (@(posedge clk) disable iff (rst)
        pin_out == (fb_out ^ {LANES{cfg_invert}}));

    // R7
    oe_chk: assert property (@(posedge clk) disable iff (rst)
        pin_oe == !cfg_buried);
endmodule

bind mc_macrocell mc_macrocell_chk #(.LANES(LANES)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .tick_a      (tick_a),
    .tick_b      (tick_b),
    .latch_en    (latch_en),
    .sum_in      (sum_in),
    .cfg_mode    (cfg_mode),
    .cfg_t_type  (cfg_t_type),
    .cfg_invert  (cfg_invert),
    .cfg_clk_sel (cfg_clk_sel),
    .cfg_buried  (cfg_buried),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .fb_out      (fb_out)
);

// File: tb/mc_macrocell_tb_top.sv
module mc_macrocell_tb_top;
    localparam int LANES = 4;
    localparam int CYC_PER_CFG = 24;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick_a = 1'b0, tick_b = 1'b0, latch_en = 1'b0;
    logic [LANES-1:0] sum_in = '0, pin_in = '0;
    logic [1:0]       cfg_mode = 2'd0;
    logic             cfg_t_type = 1'b0, cfg_invert = 1'b0, cfg_clk_sel = 1'b0;
    logic             cfg_buried = 1'b0, cfg_in_latch = 1'b0;
    logic [LANES-1:0] pin_out, fb_out, in_fb;
    logic             pin_oe;

    mc_macrocell #(.LANES(LANES), .HAS_INCAP(1'b1)) dut_i (
        .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b), .latch_en(latch_en),
        .sum_in(sum_in), .pin_in(pin_in), .cfg_mode(cfg_mode), .cfg_t_type(cfg_t_type),
        .cfg_invert(cfg_invert), .cfg_clk_sel(cfg_clk_sel), .cfg_buried(cfg_buried),
        .cfg_in_latch(cfg_in_latch), .pin_out(pin_out), .pin_oe(pin_oe),
        .fb_out(fb_out), .in_fb(in_fb)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [LANES-1:0] fb;
        logic [LANES-1:0] pin;
        logic             oe;
        logic [LANES-1:0] inp;
        string            fb_tag;
        string            in_tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    logic [LANES-1:0] m_q, m_h, m_ic;
    bit               first_after_rst;

    task automatic check(input string tag, input logic [LANES-1:0] act,
                         input logic [LANES-1:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (mode %0d t %0b inv %0b sel %0b bur %0b inl %0b)",
                     tag, act, expv, cfg_mode, cfg_t_type, cfg_invert, cfg_clk_sel,
                     cfg_buried, cfg_in_latch);
        end
    endtask

    task automatic do_reset(input logic [1:0] md, input bit t, input bit inv,
                            input bit sel, input bit bur, input bit inl);
        @(negedge clk);
        rst = 1'b1;
        cfg_mode = md; cfg_t_type = t; cfg_invert = inv;
        cfg_clk_sel = sel; cfg_buried = bur; cfg_in_latch = inl;
        tick_a = 1'b1; tick_b = 1'b1; latch_en = 1'b0;
        sum_in = '1; pin_in = '1;
        m_q = '0; m_h = '0; m_ic = '0;
        first_after_rst = 1'b1;
    endtask

    // Driver: drives one cycle, pushes the expected outputs, advances the model
    task automatic step(input logic [LANES-1:0] s, input logic [LANES-1:0] p,
                        input bit le, input bit ta, input bit tb);
        exp_t e;
        bit   tk;
        @(negedge clk);
        rst = 1'b0;
        sum_in = s; pin_in = p; latch_en = le; tick_a = ta; tick_b = tb;
        case (cfg_mode)
            2'd0: begin e.fb = s; e.fb_tag = "R1"; end
            2'd1: begin e.fb = le ? s : m_h; e.fb_tag = "R2"; end
            default: begin
                e.fb = m_q;
                e.fb_tag = cfg_t_type ? "R4 R5" : "R3 R5";
            end
        endcase
        if (first_after_rst && cfg_mode[1]) e.fb_tag = "R10";
        e.pin = e.fb ^ {LANES{cfg_invert}};
        e.oe  = !cfg_buried;
        e.inp = cfg_in_latch ? (le ? p : m_ic) : m_ic;
        e.in_tag = first_after_rst ? "R10" : (cfg_in_latch ? "R9" : "R8 R5");
        exp_q.push_back(e);
        first_after_rst = 1'b0;
        tk = cfg_clk_sel ? tb : ta;
        if (le) m_h = s;
        if (tk) m_q = cfg_t_type ? (m_q ^ s) : s;
        if (cfg_in_latch) begin
            if (le) m_ic = p;
        end else if (tk) begin
            m_ic = p;
        end
    endtask

    // Monitor: pops expected items and compares them against the ports
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.fb_tag, fb_out, e.fb);
                check("R6", pin_out, e.pin);
                check("R7", {{(LANES-1){1'b0}}, pin_oe}, {{(LANES-1){1'b0}}, e.oe});
                check(e.in_tag, in_fb, e.inp);
            end
        end
    end

    initial begin
        for (int md = 0; md < 3; md++)
            for (int t = 0; t < 2; t++)
                for (int inv = 0; inv < 2; inv++)
                    for (int sel = 0; sel < 2; sel++)
                        for (int bur = 0; bur < 2; bur++)
                            for (int inl = 0; inl < 2; inl++) begin
                                do_reset(2'(md), t[0], inv[0], sel[0], bur[0], inl[0]);
                                // directed: only the unselected strobe pulses
                                step(4'b1111, 4'b1010, 1'b0, sel[0], !sel[0]);
                                step(4'b0110, 4'b0101, 1'b1, 1'b1, 1'b1);
                                step(4'b0011, 4'b1100, 1'b0, sel[0], !sel[0]);
                                for (int c = 0; c < CYC_PER_CFG; c++)
                                    step(LANES'($urandom), LANES'($urandom),
                                         $urandom % 2 == 0, $urandom % 2 == 0,
                                         $urandom % 2 == 0);
                            end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule